// File: doc/BRIEF.md
# CPU Interrupt Entry Sequencer

This block takes control from a small CPU core's instruction sequencer once an interrupt has been accepted, and runs the fixed hardware part of interrupt entry. A request is taken only at an instruction boundary or at the internal suspend point of a long-running block-move, string-store or multiply-accumulate instruction. From the following cycle the sequencer performs these steps in order:

- an acknowledge read that returns the interrupt number and request level;
- a cleared-flags write back to the core;
- two 16-bit pushes onto the stack, holding the packed flag/PC word and the low PC word;
- a final flag write that raises the processor priority level.

It ends with a one-cycle completion pulse that carries the interrupt number, so the core can fetch the handler vector. The flag register and PC are snapshotted at acceptance. Every later step works from those copies, so the core may change its live registers while entry is in progress.

Only the flag register and the PC are saved by hardware. Any other register is left to the handler. The acknowledge read and the stack writes each use a valid/ready handshake, so memory wait states stretch the sequence without changing its order.

Top module: `irq_entry_seq`

## Requirements
- R1: When `irq_pending_i` is high, the block is idle, and `instr_done_i` or `suspend_pt_i` is high at a clock edge, `ack_req_o` is high from the next cycle on. Without a strobe, without a pending request, or while `busy_o` is high, nothing is started.
- R2: The acknowledge read drives `ack_addr_o` = 0 and holds `ack_req_o` until `ack_ready_i`. In `ack_data_i`, bits [5:0] are the interrupt number, bits [10:8] are the request level, and bit 15 marks a software INT instruction as the source.
- R3: The flag word and the PC used by every later step are the values of `flg_i` and `pc_i` at the accepting edge. Later changes on those inputs have no effect.
- R4: In the cycle after the acknowledge handshake, `flg_we_o` is high and `flg_o` is the snapshot with I (bit 6), D (bit 5) and U (bit 7) cleared. U keeps its snapshot value when the source is software and the number is 32 to 63.
- R5: The stack base is `usp_i` when the updated U is 1 and `isp_i` when it is 0, sampled in the flag-clear cycle.
- R6: In the cycle after the flag-clear cycle, the first push is presented at base-2 with data {F[15:12], PC[19:16], F[7:0]}, where F is the flag snapshot.
- R7: After the first write handshake, the second push is presented at base-4 with data PC[15:0].
- R8: While `mem_wvalid_o` is high and `mem_wready_i` is low, the write stays valid with unchanged address and data.
- R9: In the cycle after the second write handshake, `flg_we_o` is high with `flg_o` equal to the cleared flags with bits [14:12] set to the request level. In the same cycle `sp_we_o` is high with `sp_o` = base-4 and `sp_user_o` = updated U, and `done_o` pulses once with `vec_num_o` = interrupt number. `busy_o` falls in the next cycle.
- R10: After reset the block is idle: `busy_o`, `ack_req_o`, `mem_wvalid_o`, `flg_we_o`, `sp_we_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done_i | input | 1 | Instruction completes this cycle |
| suspend_pt_i | input | 1 | Long instruction at its suspend point |
| irq_pending_i | input | 1 | An interrupt request is pending |
| flg_i | input | 16 | Current flag register |
| pc_i | input | 20 | Current program counter |
| isp_i | input | 16 | Interrupt stack pointer |
| usp_i | input | 16 | User stack pointer |
| ack_req_o | output | 1 | Acknowledge read request |
| ack_addr_o | output | 20 | Acknowledge read address (always 0) |
| ack_ready_i | input | 1 | Acknowledge data valid |
| ack_data_i | input | 16 | Interrupt number, level and source |
| mem_wvalid_o | output | 1 | Stack write valid |
| mem_wready_i | input | 1 | Stack write accepted |
| mem_waddr_o | output | 16 | Stack write address |
| mem_wdata_o | output | 16 | Stack write data |
| flg_we_o | output | 1 | Flag register write enable |
| flg_o | output | 16 | New flag register value |
| sp_we_o | output | 1 | Stack pointer write enable |
| sp_user_o | output | 1 | Which pointer to write: 1 user, 0 interrupt |
| sp_o | output | 16 | New stack pointer value |
| busy_o | output | 1 | Entry sequence in progress |
| done_o | output | 1 | Entry complete, vector fetch may start |
| vec_num_o | output | 6 | Accepted interrupt number |

## Verification
Each step is due exactly one cycle after the handshake or edge that ends the step before it:
- the acknowledge request follows the accepting edge;
- the flag clear follows the acknowledge handshake;
- the first push follows the flag clear;
- the second push follows the first write handshake;
- the priority raise and the completion pulse follow the second write handshake.

The bench drives inputs and samples outputs on the falling edge. It steps a phase counter once per cycle, so every check lands on the one cycle its result is due. A missing or late output fails in that cycle rather than being waited for. Wait states on both ports are varied across the sweep, and the bench checks address and data again on every stalled cycle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int PC_W   = 20;
  localparam int FLG_W  = 16;
  localparam int SP_W   = 16;
  localparam int WORD_W = 16;
  localparam int NUM_W  = 6;
  localparam int LVL_W  = 3;

  localparam int BIT_U  = 7;
  localparam int BIT_I  = 6;
  localparam int BIT_D  = 5;
  localparam int IPL_LO = 12;
  localparam int IPL_HI = IPL_LO + LVL_W - 1;

  localparam int ACK_NUM_LO = 0;
  localparam int ACK_LVL_LO = 8;
  localparam int ACK_SW_BIT = 15;

  localparam int SW_KEEPU_MIN = 32;
  localparam logic [SP_W-1:0] STEP = SP_W'(2);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACK   = 3'd1,
    ST_CLEAR = 3'd2,
    ST_PUSH1 = 3'd3,
    ST_PUSH2 = 3'd4,
    ST_FIN   = 3'd5
  } entry_state_t;

  function automatic logic [WORD_W-1:0] pack_first(input logic [FLG_W-1:0] f,
                                                   input logic [PC_W-1:0]  pc);
    return {f[15:12], pc[19:16], f[7:0]};
  endfunction
endpackage

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept_i,
  input  logic         ack_ready_i,
  input  logic         mem_wready_i,
  output entry_state_t state_o
);
  entry_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept_i)     state_d = ST_ACK;
      ST_ACK:   if (ack_ready_i)  state_d = ST_CLEAR;
      ST_CLEAR:                   state_d = ST_PUSH1;
      ST_PUSH1: if (mem_wready_i) state_d = ST_PUSH2;
      ST_PUSH2: if (mem_wready_i) state_d = ST_FIN;
      ST_FIN:                     state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/irq_entry_flags.sv
module irq_entry_flags
  import irq_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  entry_state_t      state_i,
  input  logic              accept_i,
  input  logic              ack_ready_i,
  input  logic [FLG_W-1:0]  flg_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [WORD_W-1:0] ack_data_i,
  output logic [FLG_W-1:0]  tmp_flg_o,
  output logic [PC_W-1:0]   pc_snap_o,
  output logic [FLG_W-1:0]  flg_clr_o,
  output logic [FLG_W-1:0]  flg_fin_o,
  output logic              u_new_o,
  output logic [NUM_W-1:0]  num_o
);
  logic [FLG_W-1:0] tmp_q, tmp_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [NUM_W-1:0] num_q, num_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             sw_q, sw_d;
  logic             snap_en, ack_en, keep_u;

  assign snap_en = (state_i == ST_IDLE) && accept_i;
  assign ack_en  = (state_i == ST_ACK) && ack_ready_i;

  always_comb begin
    tmp_d = tmp_q;
    pc_d  = pc_q;
    num_d = num_q;
    lvl_d = lvl_q;
    sw_d  = sw_q;
    if (snap_en) begin
      tmp_d = flg_i;
      pc_d  = pc_i;
    end
    if (ack_en) begin
      num_d = ack_data_i[ACK_NUM_LO +: NUM_W];
      lvl_d = ack_data_i[ACK_LVL_LO +: LVL_W];
      sw_d  = ack_data_i[ACK_SW_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q <= '0;
      pc_q  <= '0;
      num_q <= '0;
      lvl_q <= '0;
      sw_q  <= 1'b0;
    end else begin
      tmp_q <= tmp_d;
      pc_q  <= pc_d;
      num_q <= num_d;
      lvl_q <= lvl_d;
      sw_q  <= sw_d;
    end
  end

  assign keep_u = sw_q && (int'(num_q) >= SW_KEEPU_MIN);
  assign u_new_o = keep_u ? tmp_q[BIT_U] : 1'b0;

  always_comb begin
    flg_clr_o        = tmp_q;
    flg_clr_o[BIT_I] = 1'b0;
    flg_clr_o[BIT_D] = 1'b0;
    flg_clr_o[BIT_U] = u_new_o;
    flg_fin_o        = flg_clr_o;
    flg_fin_o[IPL_HI:IPL_LO] = lvl_q;
  end

  assign tmp_flg_o = tmp_q;
  assign pc_snap_o = pc_q;
  assign num_o     = num_q;
endmodule

// File: rtl/irq_entry_stack.sv
module irq_entry_stack
  import irq_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  entry_state_t      state_i,
  input  logic              u_new_i,
  input  logic [SP_W-1:0]   isp_i,
  input  logic [SP_W-1:0]   usp_i,
  input  logic [FLG_W-1:0]  tmp_flg_i,
  input  logic [PC_W-1:0]   pc_snap_i,
  output logic [SP_W-1:0]   waddr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [SP_W-1:0]   sp_new_o,
  output logic              sp_user_o
);
  logic [SP_W-1:0] base_q, base_d;
  logic            user_q, user_d;
  logic            cap_en;

  assign cap_en = (state_i == ST_CLEAR);

  always_comb begin
    base_d = base_q;
    user_d = user_q;
    if (cap_en) begin
      base_d = u_new_i ? usp_i : isp_i;
      user_d = u_new_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      user_q <= 1'b0;
    end else begin
      base_q <= base_d;
      user_q <= user_d;
    end
  end

  always_comb begin
    if (state_i == ST_PUSH2) begin
      waddr_o = base_q - (STEP << 1);
      wdata_o = pc_snap_i[WORD_W-1:0];
    end else begin
      waddr_o = base_q - STEP;
      wdata_o = pack_first(tmp_flg_i, pc_snap_i);
    end
  end

  assign sp_new_o  = base_q - (STEP << 1);
  assign sp_user_o = user_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done_i,
  input  logic              suspend_pt_i,
  input  logic              irq_pending_i,
  input  logic [FLG_W-1:0]  flg_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [SP_W-1:0]   isp_i,
  input  logic [SP_W-1:0]   usp_i,
  output logic              ack_req_o,
  output logic [PC_W-1:0]   ack_addr_o,
  input  logic              ack_ready_i,
  input  logic [WORD_W-1:0] ack_data_i,
  output logic              mem_wvalid_o,
  input  logic              mem_wready_i,
  output logic [SP_W-1:0]   mem_waddr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              flg_we_o,
  output logic [FLG_W-1:0]  flg_o,
  output logic              sp_we_o,
  output logic              sp_user_o,
  output logic [SP_W-1:0]   sp_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [NUM_W-1:0]  vec_num_o
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  entry_state_t     state;
  logic             accept;
  logic [FLG_W-1:0] tmp_flg, flg_clr, flg_fin;
  logic [PC_W-1:0]  pc_snap;
  logic             u_new;

  assign accept = irq_pending_i && (instr_done_i || suspend_pt_i);

  irq_entry_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .accept_i     (accept),
    .ack_ready_i  (ack_ready_i),
    .mem_wready_i (mem_wready_i),
    .state_o      (state)
  );

  irq_entry_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .state_i     (state),
    .accept_i    (accept),
    .ack_ready_i (ack_ready_i),
    .flg_i       (flg_i),
    .pc_i        (pc_i),
    .ack_data_i  (ack_data_i),
    .tmp_flg_o   (tmp_flg),
    .pc_snap_o   (pc_snap),
    .flg_clr_o   (flg_clr),
    .flg_fin_o   (flg_fin),
    .u_new_o     (u_new),
    .num_o       (vec_num_o)
  );

  irq_entry_stack u_stack (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .state_i   (state),
    .u_new_i   (u_new),
    .isp_i     (isp_i),
    .usp_i     (usp_i),
    .tmp_flg_i (tmp_flg),
    .pc_snap_i (pc_snap),
    .waddr_o   (mem_waddr_o),
    .wdata_o   (mem_wdata_o),
    .sp_new_o  (sp_o),
    .sp_user_o (sp_user_o)
  );

  assign busy_o       = (state != ST_IDLE);
  assign ack_req_o    = (state == ST_ACK);
  assign ack_addr_o   = '0;
  assign mem_wvalid_o = (state == ST_PUSH1) || (state == ST_PUSH2);
  assign flg_we_o     = (state == ST_CLEAR) || (state == ST_FIN);
  assign flg_o        = (state == ST_FIN) ? flg_fin : flg_clr;
  assign sp_we_o      = (state == ST_FIN);
  assign done_o       = (state == ST_FIN);
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_done_i,
  input logic        suspend_pt_i,
  input logic        irq_pending_i,
  input logic        busy_o,
  input logic        ack_req_o,
  input logic [19:0] ack_addr_o,
  input logic        mem_wvalid_o,
  input logic        mem_wready_i,
  input logic [15:0] mem_waddr_o,
  input logic [15:0] mem_wdata_o,
  input logic        flg_we_o,
  input logic        sp_we_o,
  input logic        done_o
);
  a_r1_start_next: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && irq_pending_i && (instr_done_i || suspend_pt_i)) |=> ack_req_o);

  a_r2_ack_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |-> (ack_addr_o == 20'd0));

  a_r8_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid_o && !mem_wready_i) |=>
      (mem_wvalid_o && $stable(mem_waddr_o) && $stable(mem_wdata_o)));

  a_r9_done_writes: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sp_we_o && flg_we_o));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ack_req_o && !mem_wvalid_o && !flg_we_o && !sp_we_o && !done_o));

  a_r6_steps_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_req_o, mem_wvalid_o, done_o}));
endmodule

bind irq_entry_seq irq_entry_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_done_i  (instr_done_i),
  .suspend_pt_i  (suspend_pt_i),
  .irq_pending_i (irq_pending_i),
  .busy_o        (busy_o),
  .ack_req_o     (ack_req_o),
  .ack_addr_o    (ack_addr_o),
  .mem_wvalid_o  (mem_wvalid_o),
  .mem_wready_i  (mem_wready_i),
  .mem_waddr_o   (mem_waddr_o),
  .mem_wdata_o   (mem_wdata_o),
  .flg_we_o      (flg_we_o),
  .sp_we_o       (sp_we_o),
  .done_o        (done_o)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_done_i, suspend_pt_i, irq_pending_i;
  logic [15:0] flg_i;
  logic [19:0] pc_i;
  logic [15:0] isp_i, usp_i;
  logic        ack_req_o;
  logic [19:0] ack_addr_o;
  logic        ack_ready_i;
  logic [15:0] ack_data_i;
  logic        mem_wvalid_o, mem_wready_i;
  logic [15:0] mem_waddr_o, mem_wdata_o;
  logic        flg_we_o;
  logic [15:0] flg_o;
  logic        sp_we_o, sp_user_o;
  logic [15:0] sp_o;
  logic        busy_o, done_o;
  logic [5:0]  vec_num_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .instr_done_i(instr_done_i), .suspend_pt_i(suspend_pt_i), .irq_pending_i(irq_pending_i),
    .flg_i(flg_i), .pc_i(pc_i), .isp_i(isp_i), .usp_i(usp_i),
    .ack_req_o(ack_req_o), .ack_addr_o(ack_addr_o), .ack_ready_i(ack_ready_i), .ack_data_i(ack_data_i),
    .mem_wvalid_o(mem_wvalid_o), .mem_wready_i(mem_wready_i), .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o),
    .flg_we_o(flg_we_o), .flg_o(flg_o), .sp_we_o(sp_we_o), .sp_user_o(sp_user_o), .sp_o(sp_o),
    .busy_o(busy_o), .done_o(done_o), .vec_num_o(vec_num_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_seq(input int num, input bit sw, input int lvl, input logic [15:0] f,
                         input logic [19:0] pc, input logic [15:0] isp, input logic [15:0] usp,
                         input bit susp, input int aw_in, input int w1_in, input int w2_in,
                         input bit poke);
    logic [15:0] clr, fin, base, w1d;
    bit          unew, done_seen;
    int          phase, aw, w1, w2;
    unew = (sw && num >= 32) ? f[7] : 1'b0;
    clr = f; clr[6] = 1'b0; clr[5] = 1'b0; clr[7] = unew;
    fin = clr; fin[14:12] = lvl[2:0];
    base = unew ? usp : isp;
    w1d = {f[15:12], pc[19:16], f[7:0]};
    aw = aw_in; w1 = w1_in; w2 = w2_in;
    @(negedge clk);
    flg_i = f; pc_i = pc; isp_i = isp; usp_i = usp;
    ack_data_i = {sw, 4'b1010, lvl[2:0], 2'b01, num[5:0]};
    irq_pending_i = 1'b1;
    instr_done_i = !susp; suspend_pt_i = susp;
    @(negedge clk);
    chk(ack_req_o && busy_o, "R1 ack one cycle after strobe", {30'd0, busy_o, ack_req_o}, 32'h3);
    instr_done_i = poke; suspend_pt_i = 1'b0; irq_pending_i = poke;
    flg_i = ~f; pc_i = ~pc;
    if (poke) begin isp_i = ~isp; usp_i = ~usp; end
    phase = 0; done_seen = 0;
    for (int c = 0; c < 40 && !done_seen; c++) begin
      if (c > 0) @(negedge clk);
      ack_ready_i = 1'b0; mem_wready_i = 1'b0;
      case (phase)
        0: begin
          chk(ack_req_o && ack_addr_o == 20'd0 && !mem_wvalid_o, "R2 ack read at zero",
              {11'd0, ack_req_o, ack_addr_o}, 32'h0010_0000);
          if (aw > 0) aw--; else begin ack_ready_i = 1'b1; phase = 1; end
        end
        1: begin
          chk(flg_we_o && flg_o == clr && !ack_req_o, "R4 R3 flag clear step",
              {15'd0, flg_we_o, flg_o}, {15'd0, 1'b1, clr});
          isp_i = isp; usp_i = usp;
          phase = 2;
          isp_i = isp; usp_i = usp;
        end
        2: begin
          chk(mem_wvalid_o && mem_waddr_o == base - 16'd2, "R5 R6 first push address",
              {15'd0, mem_wvalid_o, mem_waddr_o}, {15'd0, 1'b1, base - 16'd2});
          chk(mem_wdata_o == w1d, (w1 > 0) ? "R8 first push data held" : "R6 R3 first push data",
              {16'd0, mem_wdata_o}, {16'd0, w1d});
          if (w1 > 0) w1--; else begin mem_wready_i = 1'b1; phase = 3; end
        end
        3: begin
          chk(mem_wvalid_o && mem_waddr_o == base - 16'd4, "R7 second push address",
              {15'd0, mem_wvalid_o, mem_waddr_o}, {15'd0, 1'b1, base - 16'd4});
          chk(mem_wdata_o == pc[15:0], (w2 > 0) ? "R8 second push data held" : "R7 R3 second push data",
              {16'd0, mem_wdata_o}, {16'd0, pc[15:0]});
          if (w2 > 0) w2--; else begin mem_wready_i = 1'b1; phase = 4; end
        end
        default: begin
          instr_done_i = 1'b0; irq_pending_i = 1'b0;
          chk(done_o && vec_num_o == num[5:0], "R9 done with number",
              {25'd0, done_o, vec_num_o}, {25'd0, 1'b1, num[5:0]});
          chk(flg_we_o && flg_o == fin, "R9 priority level raised",
              {15'd0, flg_we_o, flg_o}, {15'd0, 1'b1, fin});
          chk(sp_we_o && sp_o == base - 16'd4 && sp_user_o == unew, "R9 R5 stack pointer update",
              {14'd0, sp_we_o, sp_user_o, sp_o}, {14'd0, 1'b1, unew, base - 16'd4});
          done_seen = 1;
        end
      endcase
    end
    chk(done_seen, "R9 sequence completed", {31'd0, done_seen}, 32'd1);
    @(negedge clk);
    ack_ready_i = 1'b0; mem_wready_i = 1'b0;
    chk(!busy_o && !done_o, poke ? "R1 strobe while busy ignored" : "R9 busy falls after done",
        {30'd0, busy_o, done_o}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    instr_done_i = 0; suspend_pt_i = 0; irq_pending_i = 0;
    flg_i = '0; pc_i = '0; isp_i = '0; usp_i = '0;
    ack_ready_i = 0; ack_data_i = '0; mem_wready_i = 0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !ack_req_o && !mem_wvalid_o && !flg_we_o && !sp_we_o && !done_o,
        "R10 reset idle", {26'd0, busy_o, ack_req_o, mem_wvalid_o, flg_we_o, sp_we_o, done_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o, "R10 idle after reset release", {30'd0, busy_o, done_o}, 32'd0);

    instr_done_i = 1'b1; irq_pending_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!busy_o && !ack_req_o, "R1 strobe without request ignored", {30'd0, busy_o, ack_req_o}, 32'd0);
    instr_done_i = 1'b0; irq_pending_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!busy_o && !ack_req_o, "R1 request without strobe ignored", {30'd0, busy_o, ack_req_o}, 32'd0);
    irq_pending_i = 1'b0;

    for (int n = 0; n < 64; n++) begin
      for (int s = 0; s < 2; s++) begin
        logic [15:0] f;
        logic [19:0] pc;
        f  = 16'((n * 1187 + s * 40503) ^ (n << 9) ^ 16'h00A0);
        if (n[1]) f[7] = 1'b1;
        pc = 20'((n * 23719 + s * 99991 + 20'h5A3C7) & 20'hFFFFF);
        run_seq(n, s[0], (n + s) % 8, f, pc,
                16'h8000 + 16'(n * 6), 16'hC000 + 16'(n * 10),
                n[0], n % 3, (n / 3) % 3, (n + s) % 2, (n % 5) == 0);
      end
    end

    repeat (2) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule